// File: doc/BRIEF.md
# Instruction Fetch Address Translation Buffer

This block translates the word address of every instruction fetch from a virtual page to a physical page. The virtual address holds a 5-bit page number over a 6-bit word offset, so it covers 32 pages of 64 words. Eight translations are cached. The fetch side presents a virtual address with a valid strobe. On a hit, the block returns the physical address and a hit flag in the same cycle, and it does not stall.

On a miss, the block raises a stall and reads the page table entry for that page from main memory. The page table is a fixed array of one word per virtual page, starting at a base word address (default 0) and indexed by the page number. The block waits for the memory to answer and writes the entry into a slot. It then releases the stall in the next cycle, because the held fetch now hits. A memory that answers three cycles after the request gives a miss cost of four stall cycles.

Free slots are filled first. Once all eight are in use, a free-running pseudo-random sequence picks the slot to replace. Each slot keeps a reference bit and a dirty bit. When a dirty slot is replaced, the block sends out a one-cycle notice carrying the page number, frame number and reference bit of that slot, so that the page table can be updated.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset no translation is held: the first fetch of any page misses and stalls, and no eviction notice or table read is active while the fetch strobe is low.
- R2: The low 6 bits of the physical address always equal the low 6 bits of the virtual address, for offsets 0 through 63.
- R3: A fetch whose page is held returns hit=1 and stall=0 in the same cycle, with physical address {frame number, offset}, and issues no table read.
- R4: A fetch that misses raises stall in the same cycle. From the next cycle, the table read request is high with address = base + page number, and the request and address are held until ready is seen.
- R5: In the cycle ready is high, the table word is installed: bits [4:0] are the frame number and bit 5 is the dirty flag. The request drops after that edge, and the held fetch hits in the next cycle. With a memory answering 3 cycles after the request, a miss stalls for exactly 4 cycles.
- R6: While a free slot exists, a miss fills it without displacing any held page: eight distinct pages all become and stay resident.
- R7: When all slots are full, a miss replaces exactly one held page, and the other seven still hit.
- R8: Replacing a slot whose dirty flag is set gives an eviction notice that is high for exactly one cycle, in the cycle after ready, carrying that slot's page and frame numbers. Replacing a clean slot gives no notice.
- R9: A slot's reference bit is 0 after install, including the completing lookup, and is set by any later hit on it. The notice reports this bit.
- R10: With the fetch strobe low, hit and stall are both 0 and no table read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all slots |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_vaddr_i | input | 11 | Virtual word address {page, offset} |
| fetch_paddr_o | output | 11 | Physical word address {frame, offset} |
| fetch_hit_o | output | 1 | Translation available this cycle |
| fetch_stall_o | output | 1 | Fetch must hold its address |
| pt_rd_req_o | output | 1 | Page table read request |
| pt_rd_addr_o | output | 16 | Page table word address |
| pt_rd_ready_i | input | 1 | Table word present on data input |
| pt_rd_data_i | input | 6 | Table word {dirty, frame} |
| evict_valid_o | output | 1 | Dirty slot replaced (one-cycle pulse) |
| evict_vpn_o | output | 5 | Page number of the replaced slot |
| evict_ppn_o | output | 5 | Frame number of the replaced slot |
| evict_ref_o | output | 1 | Reference bit of the replaced slot |

## Verification
A corrupted tag or frame field shows on the first fetch of that page. It appears either as a wrong physical address in the same cycle, or as an unexpected stall followed by a table read with a visible address. A slot filled twice, or a free slot skipped, shows later as a miss on a page that should be resident, or as an eviction notice while slots were still free. A reference or dirty bit held wrongly stays hidden until that slot is replaced. The dirty-eviction test therefore drives the notice so that both bits are compared against the known access history.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;

    // Walker state of the miss sequence
    typedef enum logic [0:0] {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_e;

    // Pseudo-random source: 8-bit Galois shift register, maximal length
    localparam int          RNG_W    = 8;
    localparam logic [7:0]  RNG_TAPS = 8'hB8;
    localparam logic [7:0]  RNG_SEED = 8'h01;

endpackage

// File: rtl/ifetch_tlb_match.sv
module ifetch_tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 5,
    parameter int PPN_W   = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       valid_i,
    input  logic [ENTRIES*VPN_W-1:0] tag_i,
    input  logic [ENTRIES*PPN_W-1:0] ppn_i,
    input  logic [VPN_W-1:0]         vpn_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic [PPN_W-1:0]         ppn_o
);

    logic [ENTRIES-1:0] match;

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tag_i[g*VPN_W +: VPN_W] == vpn_i);
    end

    // At most one slot matches, so an OR of gated fields is enough
    always_comb begin
        ppn_o = '0;
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                ppn_o = ppn_o | ppn_i[i*PPN_W +: PPN_W];
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/ifetch_tlb_victim.sv
module ifetch_tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]   victim_o
);
    import ifetch_tlb_pkg::*;

    logic [RNG_W-1:0] rng_d, rng_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Free-running sequence, one step every cycle
    always_comb begin
        rng_d = rng_q >> 1;
        if (rng_q[0]) begin
            rng_d = rng_d ^ RNG_TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q <= RNG_SEED;
        end else begin
            rng_q <= rng_d;
        end
    end

    // Lowest free slot wins over the random pick
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim_o = free_found ? free_idx : rng_q[IDX_W-1:0];
    end

endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 5,
    parameter int OFF_W   = 6,
    parameter int PPN_W   = 5,
    parameter int MEM_AW  = 16,
    parameter int PT_BASE = 0,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int PTE_W  = PPN_W + 1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [VA_W-1:0]   fetch_vaddr_i,
    output logic [PA_W-1:0]   fetch_paddr_o,
    output logic              fetch_hit_o,
    output logic              fetch_stall_o,
    output logic              pt_rd_req_o,
    output logic [MEM_AW-1:0] pt_rd_addr_o,
    input  logic              pt_rd_ready_i,
    input  logic [PTE_W-1:0]  pt_rd_data_i,
    output logic              evict_valid_o,
    output logic [VPN_W-1:0]  evict_vpn_o,
    output logic [PPN_W-1:0]  evict_ppn_o,
    output logic              evict_ref_o
);
    import ifetch_tlb_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             refd;
        logic             dirty;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    typedef struct packed {
        walk_e                   st;
        logic                    retry;
        logic [VPN_W-1:0]        miss_vpn;
        logic                    ev_valid;
        logic                    ev_ref;
        logic [VPN_W-1:0]        ev_vpn;
        logic [PPN_W-1:0]        ev_ppn;
        slot_t [ENTRIES-1:0]     slot;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0]       vld_vec;
    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES*PPN_W-1:0] ppn_flat;
    logic [VPN_W-1:0]         look_vpn;
    logic                     m_hit;
    logic [IDX_W-1:0]         m_idx;
    logic [PPN_W-1:0]         m_ppn;
    logic [IDX_W-1:0]         victim;

    assign look_vpn = fetch_vaddr_i[VA_W-1:OFF_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign vld_vec[g]                  = state_q.slot[g].valid;
        assign tag_flat[g*VPN_W +: VPN_W]  = state_q.slot[g].tag;
        assign ppn_flat[g*PPN_W +: PPN_W]  = state_q.slot[g].ppn;
    end

    ifetch_tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) match_i (
        .valid_i (vld_vec),
        .tag_i   (tag_flat),
        .ppn_i   (ppn_flat),
        .vpn_i   (look_vpn),
        .hit_o   (m_hit),
        .idx_o   (m_idx),
        .ppn_o   (m_ppn)
    );

    ifetch_tlb_victim #(
        .ENTRIES (ENTRIES)
    ) victim_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (vld_vec),
        .victim_o (victim)
    );

    // Next-state logic
    always_comb begin
        state_d          = state_q;
        state_d.ev_valid = 1'b0;
        state_d.retry    = 1'b0;
        unique case (state_q.st)
            WALK_IDLE: begin
                if (fetch_valid_i) begin
                    if (m_hit) begin
                        // the completing lookup of a refill does not count as a use
                        if (!state_q.retry) begin
                            state_d.slot[m_idx].refd = 1'b1;
                        end
                    end else begin
                        state_d.st       = WALK_BUSY;
                        state_d.miss_vpn = look_vpn;
                    end
                end
            end
            WALK_BUSY: begin
                if (pt_rd_ready_i) begin
                    if (state_q.slot[victim].valid && state_q.slot[victim].dirty) begin
                        state_d.ev_valid = 1'b1;
                        state_d.ev_ref   = state_q.slot[victim].refd;
                        state_d.ev_vpn   = state_q.slot[victim].tag;
                        state_d.ev_ppn   = state_q.slot[victim].ppn;
                    end
                    state_d.slot[victim].valid = 1'b1;
                    state_d.slot[victim].refd  = 1'b0;
                    state_d.slot[victim].dirty = pt_rd_data_i[PPN_W];
                    state_d.slot[victim].tag   = state_q.miss_vpn;
                    state_d.slot[victim].ppn   = pt_rd_data_i[PPN_W-1:0];
                    state_d.st                 = WALK_IDLE;
                    state_d.retry              = 1'b1;
                end
            end
            default: state_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    assign fetch_hit_o   = fetch_valid_i && (state_q.st == WALK_IDLE) && m_hit;
    assign fetch_stall_o = fetch_valid_i && !fetch_hit_o;
    assign fetch_paddr_o = {m_ppn, fetch_vaddr_i[OFF_W-1:0]};
    assign pt_rd_req_o   = (state_q.st == WALK_BUSY);
    assign pt_rd_addr_o  = MEM_AW'(PT_BASE) + MEM_AW'(state_q.miss_vpn);
    assign evict_valid_o = state_q.ev_valid;
    assign evict_vpn_o   = state_q.ev_vpn;
    assign evict_ppn_o   = state_q.ev_ppn;
    assign evict_ref_o   = state_q.ev_ref;

endmodule

// File: rtl/ifetch_tlb_chk.sv
module ifetch_tlb_chk #(
    parameter int OFF_W  = 6,
    parameter int VA_W   = 11,
    parameter int PA_W   = 11,
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid_i,
    input logic [VA_W-1:0]   fetch_vaddr_i,
    input logic [PA_W-1:0]   fetch_paddr_o,
    input logic              fetch_hit_o,
    input logic              fetch_stall_o,
    input logic              pt_rd_req_o,
    input logic [MEM_AW-1:0] pt_rd_addr_o,
    input logic              pt_rd_ready_i,
    input logic              evict_valid_o
);

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit_o |-> fetch_paddr_o[OFF_W-1:0] == fetch_vaddr_i[OFF_W-1:0]);

    // R3
    hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit_o |-> (!fetch_stall_o && !pt_rd_req_o));

    // R4
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rd_req_o && !pt_rd_ready_i) |=> (pt_rd_req_o && $stable(pt_rd_addr_o)));

    // R5
    walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rd_req_o && pt_rd_ready_i) |=> !pt_rd_req_o);

    // R8
    evict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid_o |=> !evict_valid_o);

    // R8
    evict_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid_o |-> $past(pt_rd_req_o && pt_rd_ready_i));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |-> (!fetch_stall_o && !fetch_hit_o));

endmodule

bind ifetch_tlb ifetch_tlb_chk #(
    .OFF_W  (OFF_W),
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .MEM_AW (MEM_AW)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .fetch_vaddr_i (fetch_vaddr_i),
    .fetch_paddr_o (fetch_paddr_o),
    .fetch_hit_o   (fetch_hit_o),
    .fetch_stall_o (fetch_stall_o),
    .pt_rd_req_o   (pt_rd_req_o),
    .pt_rd_addr_o  (pt_rd_addr_o),
    .pt_rd_ready_i (pt_rd_ready_i),
    .evict_valid_o (evict_valid_o)
);

// File: tb/ifetch_tlb_tb.sv
module ifetch_tlb_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int MISS_STALL = LAT + 1;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [10:0] fetch_vaddr_i = '0;
    logic [10:0] fetch_paddr_o;
    logic        fetch_hit_o;
    logic        fetch_stall_o;
    logic        pt_rd_req_o;
    logic [15:0] pt_rd_addr_o;
    logic        pt_rd_ready_i = 1'b0;
    logic [5:0]  pt_rd_data_i = '0;
    logic        evict_valid_o;
    logic [4:0]  evict_vpn_o;
    logic [4:0]  evict_ppn_o;
    logic        evict_ref_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    // memory responder state
    int          resp_cnt = 0;
    int          first_req_addr = -1;
    // eviction monitor state
    int          ev_cnt = 0;
    int          ev_vpn = 0;
    int          ev_ppn = 0;
    int          ev_ref = 0;

    ifetch_tlb dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid_i (fetch_valid_i),
        .fetch_vaddr_i (fetch_vaddr_i),
        .fetch_paddr_o (fetch_paddr_o),
        .fetch_hit_o   (fetch_hit_o),
        .fetch_stall_o (fetch_stall_o),
        .pt_rd_req_o   (pt_rd_req_o),
        .pt_rd_addr_o  (pt_rd_addr_o),
        .pt_rd_ready_i (pt_rd_ready_i),
        .pt_rd_data_i  (pt_rd_data_i),
        .evict_valid_o (evict_valid_o),
        .evict_vpn_o   (evict_vpn_o),
        .evict_ppn_o   (evict_ppn_o),
        .evict_ref_o   (evict_ref_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Page table contents: frame = (7*page+3) mod 32, dirty for pages below 16
    function automatic int frame_of(input int vpn);
        return (vpn * 7 + 3) % 32;
    endfunction

    function automatic logic [5:0] pte_of(input int vpn);
        return {(vpn < 16) ? 1'b1 : 1'b0, 5'(frame_of(vpn))};
    endfunction

    // Memory model: answers LAT cycles after the request rises
    always @(negedge clk) begin
        if (pt_rd_req_o && rst_n) begin
            if (resp_cnt == 0 && first_req_addr < 0) begin
                first_req_addr <= int'(pt_rd_addr_o);
            end
            if (resp_cnt == LAT - 1) begin
                pt_rd_ready_i <= 1'b1;
                pt_rd_data_i  <= pte_of(int'(pt_rd_addr_o[4:0]));
                resp_cnt      <= 0;
            end else begin
                pt_rd_ready_i <= 1'b0;
                resp_cnt      <= resp_cnt + 1;
            end
        end else begin
            pt_rd_ready_i <= 1'b0;
            resp_cnt      <= 0;
        end
    end

    // Eviction monitor
    always @(negedge clk) begin
        if (evict_valid_o && rst_n) begin
            ev_cnt <= ev_cnt + 1;
            ev_vpn <= int'(evict_vpn_o);
            ev_ppn <= int'(evict_ppn_o);
            ev_ref <= int'(evict_ref_o);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        fetch_valid_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        first_req_addr = -1;
    endtask

    // Issue one fetch, hold it while stalled, report stall cycles and address
    task automatic fetch(input int vpn, input int off, output int stalls, output int pa);
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_vaddr_i = {5'(vpn), 6'(off)};
        stalls = 0;
        #1;
        while (fetch_stall_o && stalls < 50) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        pa = int'(fetch_paddr_o);
        @(negedge clk);
        fetch_valid_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check(!fetch_stall_o && !fetch_hit_o, "R10 no strobe gives no hit/stall", int'(fetch_stall_o), 0);
        check(!pt_rd_req_o, "R1 no table read after reset", int'(pt_rd_req_o), 0);
        check(!evict_valid_o, "R1 no eviction after reset", int'(evict_valid_o), 0);
    endtask

    task automatic t_first_miss();
        int st, pa;
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_vaddr_i = {5'd3, 6'd17};
        #1;
        check(fetch_stall_o && !fetch_hit_o, "R1 first fetch stalls", int'(fetch_stall_o), 1);
        @(negedge clk);
        #1;
        check(pt_rd_req_o && pt_rd_addr_o == 16'd3, "R4 table read at page number", int'(pt_rd_addr_o), 3);
        @(negedge clk);
        #1;
        check(pt_rd_req_o && pt_rd_addr_o == 16'd3, "R4 request held until ready", int'(pt_rd_req_o), 1);
        fetch_valid_i = 1'b0;
        // let the walk finish with the fetch re-presented
        fetch(3, 17, st, pa);
        check(pa == (frame_of(3) * 64 + 17), "R5 installed frame used", pa, frame_of(3) * 64 + 17);
        check(!pt_rd_req_o, "R5 request dropped after fill", int'(pt_rd_req_o), 0);
    endtask

    task automatic t_miss_latency();
        int st, pa;
        fetch(5, 9, st, pa);
        check(st == MISS_STALL, "R5 miss stall cycles", st, MISS_STALL);
        check(pa == frame_of(5) * 64 + 9, "R5 physical address after refill", pa, frame_of(5) * 64 + 9);
    endtask

    task automatic t_hit();
        int st, pa;
        fetch(5, 40, st, pa);
        check(st == 0, "R3 resident page does not stall", st, 0);
        check(pa == frame_of(5) * 64 + 40, "R3 hit address", pa, frame_of(5) * 64 + 40);
        check(first_req_addr == 3, "R4 first walk address", first_req_addr, 3);
    endtask

    task automatic t_offsets();
        int st, pa;
        fetch(5, 0, st, pa);
        check(pa % 64 == 0 && st == 0, "R2 offset 0 passes through", pa % 64, 0);
        fetch(5, 63, st, pa);
        check(pa % 64 == 63 && st == 0, "R2 offset 63 passes through", pa % 64, 63);
    endtask

    task automatic t_idle();
        @(negedge clk);
        fetch_valid_i = 1'b0;
        fetch_vaddr_i = {5'd30, 6'd1};
        repeat (3) @(negedge clk);
        #1;
        check(!pt_rd_req_o && !fetch_stall_o, "R10 unmapped address without strobe ignored",
              int'(pt_rd_req_o), 0);
    endtask

    task automatic t_dirty_evict();
        int st, pa, ev0, total;
        bit ok;
        do_reset();
        ev0 = ev_cnt;
        ok = 1;
        for (int v = 8; v < 16; v++) begin
            fetch(v, v, st, pa);
            if (st != MISS_STALL) ok = 0;
        end
        @(negedge clk);
        check(ok, "R6 each new page misses once", int'(ok), 1);
        check(ev_cnt == ev0, "R6 no eviction while slots free", ev_cnt - ev0, 0);
        // use even pages again
        total = 0;
        for (int v = 8; v < 16; v += 2) begin
            fetch(v, 1, st, pa);
            total += st;
        end
        check(total == 0, "R6 filled pages stay resident", total, 0);
        // ninth page forces a replacement of a dirty slot
        fetch(20, 2, st, pa);
        @(negedge clk);
        check(ev_cnt == ev0 + 1, "R8 one notice for dirty replacement", ev_cnt - ev0, 1);
        check(ev_vpn >= 8 && ev_vpn < 16, "R7 replaced page was resident", ev_vpn, 8);
        check(ev_ppn == frame_of(ev_vpn), "R8 notice carries frame", ev_ppn, frame_of(ev_vpn));
        check(ev_ref == ((ev_vpn % 2 == 0) ? 1 : 0), "R9 reference bit reflects later use",
              ev_ref, (ev_vpn % 2 == 0) ? 1 : 0);
        total = 0;
        for (int v = 8; v < 16; v++) begin
            if (v != ev_vpn) begin
                fetch(v, 3, st, pa);
                total += st;
            end
        end
        fetch(20, 4, st, pa);
        total += st;
        check(total == 0, "R7 other seven pages still hit", total, 0);
    endtask

    task automatic t_clean_evict();
        int st, pa, ev0;
        do_reset();
        ev0 = ev_cnt;
        for (int v = 16; v < 24; v++) begin
            fetch(v, 0, st, pa);
        end
        fetch(24, 5, st, pa);
        @(negedge clk);
        check(st == MISS_STALL, "R7 ninth page misses", st, MISS_STALL);
        check(ev_cnt == ev0, "R8 clean replacement gives no notice", ev_cnt - ev0, 0);
    endtask

    task automatic t_reset_clears();
        int st, pa;
        do_reset();
        fetch(24, 6, st, pa);
        check(st == MISS_STALL, "R1 reset drops held pages", st, MISS_STALL);
    endtask

    initial begin
        t_reset_state();
        t_first_miss();
        t_miss_latency();
        t_hit();
        t_offsets();
        t_idle();
        t_dirty_evict();
        t_clean_evict();
        t_reset_clears();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule